// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the vector-configuration instructions of a vector pipeline. It holds the active vector length and the active vector type, which are the element width, the register-group multiplier, the two policy bits and an illegal-type flag. Each accepted request carries a requested application length, or AVL. The AVL comes either from a scalar register value or from a 5-bit immediate. The request also carries the new type fields and two flags that say whether the source and destination register indices are x0.

On each request the unit computes the maximum length for the requested type, which is (VLEN / SEW) * LMUL. It picks one of three update behaviours from the x0 flags and the immediate-form flag. It then writes the new state and returns the new length as the scalar result. The request side is a valid/ready stream, and `req_ready` is held high. A request is accepted on every clock edge where `req_valid` is high. The unit never applies back-pressure, so the issuing stage needs no stall path. The response is a single-cycle pulse with no ready input, and the consumer must take it in the cycle it appears.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, the vector length is 0, the illegal flag is 1, the width, multiplier and policy fields are 0, and `rsp_valid` is 0.
- R2: The maximum length is (VLEN / SEW) * LMUL. The width code maps 000 to 8 bits, 001 to 16, 010 to 32 and 011 to 64. The multiplier code maps 00 to 1, 01 to 2, 10 to 4 and 11 to 8.
- R3: In the register form with a source that is not x0, the new length is the smaller of the AVL and the maximum length.
- R4: In the immediate form (`req_imm_form`=1), the AVL is the zero-extended 5-bit immediate. Both x0 flags are ignored, and the length is clamped as in R3.
- R5: In the register form, a source of x0 with a destination that is not x0 sets the length to the maximum length.
- R6: In the register form, a source and destination that are both x0 update only the type, and the length keeps its value. This is allowed only when the new maximum length equals the current one and the current type is legal.
- R7: A width code with bit 2 set, or a failed R6 condition, sets the illegal flag and clears the length. The width, multiplier and policy fields are also cleared.
- R8: The tail and mask policy bits are stored as given, where 1 means agnostic and 0 means undisturbed.
- R9: The new state and `rsp_vl` appear in the cycle after acceptance. `rsp_valid` is high for exactly one cycle per accepted request, and `rsp_vl` equals the new length.
- R10: `req_ready` is always 1. In a cycle with no accepted request, the state does not change and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (always 1) |
| req_imm_form | input | 1 | 1: AVL comes from the immediate |
| req_avl_reg | input | XLEN | AVL taken from a scalar register |
| req_avl_imm | input | 5 | AVL taken from the immediate |
| req_sew | input | 3 | Requested element width code |
| req_lmul | input | 2 | Requested group multiplier code |
| req_tail_agn | input | 1 | Tail policy (1 = agnostic) |
| req_mask_agn | input | 1 | Mask policy (1 = agnostic) |
| req_src_zero | input | 1 | Source register index is x0 |
| req_dst_zero | input | 1 | Destination register index is x0 |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_vl | output | XLEN | New length for the scalar destination |
| vl_o | output | VLW | Current vector length |
| vtype_ill_o | output | 1 | Current type is illegal |
| vtype_sew_o | output | 3 | Current width code |
| vtype_lmul_o | output | 2 | Current multiplier code |
| vtype_tail_agn_o | output | 1 | Current tail policy |
| vtype_mask_agn_o | output | 1 | Current mask policy |

## Verification
The assertions assume three things about the inputs. Request fields are stable and known whenever `req_valid` is high. XLEN is wider than the length field. VLEN is a power of two no smaller than 64. The bench drives every field only at falling edges, while the clock is low, and keeps the default parameters. Within those limits it sweeps every width and multiplier code in every update form. This includes all legal and illegal x0/x0 type changes from each legal starting type.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    UPD_AVL  = 2'd0,
    UPD_MAX  = 2'd1,
    UPD_KEEP = 2'd2
  } upd_mode_e;

  typedef struct packed {
    logic       ill;
    logic       tail_agn;
    logic       mask_agn;
    logic [2:0] sew;
    logic [1:0] lmul;
  } vtype_t;

endpackage

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int VLEN = 128,
  parameter int VLW  = $clog2(VLEN) + 1
) (
  input  logic [2:0]     sew,
  input  logic [1:0]     lmul,
  output logic [VLW-1:0] vlmax,
  output logic           legal
);
  localparam logic [VLW-1:0] BASE8  = VLW'(VLEN / 8);
  localparam logic [VLW-1:0] BASE16 = VLW'(VLEN / 16);
  localparam logic [VLW-1:0] BASE32 = VLW'(VLEN / 32);
  localparam logic [VLW-1:0] BASE64 = VLW'(VLEN / 64);

  logic [VLW-1:0] base;

  always_comb begin
    legal = ~sew[2];
    unique case (sew[1:0])
      2'd0:    base = BASE8;
      2'd1:    base = BASE16;
      2'd2:    base = BASE32;
      default: base = BASE64;
    endcase
    vlmax = legal ? (base << lmul) : '0;
  end
endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLW  = 8
) (
  input  upd_mode_e       mode,
  input  logic            imm_form,
  input  logic [XLEN-1:0] avl_reg,
  input  logic [4:0]      avl_imm,
  input  logic [VLW-1:0]  vlmax,
  input  logic [VLW-1:0]  cur_vl,
  output logic [VLW-1:0]  vl_next
);
  logic [XLEN-1:0] avl;
  logic [XLEN-1:0] vlmax_x;

  always_comb begin
    avl     = imm_form ? {{(XLEN-5){1'b0}}, avl_imm} : avl_reg;
    vlmax_x = {{(XLEN-VLW){1'b0}}, vlmax};
    unique case (mode)
      UPD_MAX:  vl_next = vlmax;
      UPD_KEEP: vl_next = cur_vl;
      default:  vl_next = (avl >= vlmax_x) ? vlmax : avl[VLW-1:0];
    endcase
  end
endmodule

// File: rtl/vcfg_state.sv
module vcfg_state
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  vtype_t          vtype_next,
  input  logic [VLW-1:0]  vl_next,
  output vtype_t          vtype_q,
  output logic [VLW-1:0]  vl_q,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_vl
);
  localparam vtype_t VTYPE_RST = '{ill: 1'b1, tail_agn: 1'b0, mask_agn: 1'b0,
                                   sew: 3'd0, lmul: 2'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtype_q   <= VTYPE_RST;
      vl_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_vl    <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        vtype_q <= vtype_next;
        vl_q    <= vl_next;
        rsp_vl  <= {{(XLEN-VLW){1'b0}}, vl_next};
      end
    end
  end

  // The state holds between requests (R10).
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(vl_q) && $stable(vtype_q) && !rsp_valid));

  // Each accepted request gives a result strobe that carries the new length (R9).
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid && rsp_vl == {{(XLEN-VLW){1'b0}}, vl_q}));
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_imm_form,
  input  logic [XLEN-1:0] req_avl_reg,
  input  logic [4:0]      req_avl_imm,
  input  logic [2:0]      req_sew,
  input  logic [1:0]      req_lmul,
  input  logic            req_tail_agn,
  input  logic            req_mask_agn,
  input  logic            req_src_zero,
  input  logic            req_dst_zero,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_vl,
  output logic [VLW-1:0]  vl_o,
  output logic            vtype_ill_o,
  output logic [2:0]      vtype_sew_o,
  output logic [1:0]      vtype_lmul_o,
  output logic            vtype_tail_agn_o,
  output logic            vtype_mask_agn_o
);
  upd_mode_e      mode;
  vtype_t         vtype_q, vtype_next;
  logic [VLW-1:0] vl_q, vl_clamped, vl_next;
  logic [VLW-1:0] new_vlmax, cur_vlmax;
  logic           new_legal, cur_legal_unused;
  logic           keep_bad, ill_next, accept;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;

  // Update behaviour: the immediate form always uses its AVL.
  always_comb begin
    if (req_imm_form || !req_src_zero) mode = UPD_AVL;
    else if (!req_dst_zero)            mode = UPD_MAX;
    else                               mode = UPD_KEEP;
  end

  vcfg_vlmax #(.VLEN(VLEN), .VLW(VLW)) u_new_max (
    .sew(req_sew), .lmul(req_lmul), .vlmax(new_vlmax), .legal(new_legal));

  vcfg_vlmax #(.VLEN(VLEN), .VLW(VLW)) u_cur_max (
    .sew(vtype_q.sew), .lmul(vtype_q.lmul), .vlmax(cur_vlmax),
    .legal(cur_legal_unused));

  vcfg_clamp #(.XLEN(XLEN), .VLW(VLW)) u_clamp (
    .mode(mode), .imm_form(req_imm_form), .avl_reg(req_avl_reg),
    .avl_imm(req_avl_imm), .vlmax(new_vlmax), .cur_vl(vl_q),
    .vl_next(vl_clamped));

  always_comb begin
    keep_bad = (mode == UPD_KEEP) && (vtype_q.ill || (new_vlmax != cur_vlmax));
    ill_next = !new_legal || keep_bad;
    if (ill_next) begin
      vtype_next = '{ill: 1'b1, tail_agn: 1'b0, mask_agn: 1'b0,
                     sew: 3'd0, lmul: 2'd0};
      vl_next    = '0;
    end else begin
      vtype_next = '{ill: 1'b0, tail_agn: req_tail_agn, mask_agn: req_mask_agn,
                     sew: req_sew, lmul: req_lmul};
      vl_next    = vl_clamped;
    end
  end

  vcfg_state #(.XLEN(XLEN), .VLW(VLW)) u_state (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vtype_next(vtype_next),
    .vl_next(vl_next), .vtype_q(vtype_q), .vl_q(vl_q),
    .rsp_valid(rsp_valid), .rsp_vl(rsp_vl));

  assign vl_o             = vl_q;
  assign vtype_ill_o      = vtype_q.ill;
  assign vtype_sew_o      = vtype_q.sew;
  assign vtype_lmul_o     = vtype_q.lmul;
  assign vtype_tail_agn_o = vtype_q.tail_agn;
  assign vtype_mask_agn_o = vtype_q.mask_agn;

  // A legal type never holds a length above its maximum (R3).
  assert_vl_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vtype_q.ill |-> (vl_q <= cur_vlmax));

  // An illegal type always carries a zero length (R7).
  assert_ill_clears_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_q.ill |-> (vl_q == '0));

  // A legal type-only change leaves the length alone (R6).
  assert_keep_vl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == UPD_KEEP && !ill_next) |=> (vl_q == $past(vl_q)));

  // A legal source-x0 request lands on the maximum of the stored type (R5).
  assert_max_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == UPD_MAX && new_legal) |=> (vl_q == cur_vlmax));

  // Readiness never drops (R10).
  assert_always_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/vcfg_unit_test.sv
module vcfg_unit_test;
  localparam int VLEN = 128;
  localparam int XLEN = 32;
  localparam int VLW  = $clog2(VLEN) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_ready;
  logic            req_imm_form = 1'b0;
  logic [XLEN-1:0] req_avl_reg = '0;
  logic [4:0]      req_avl_imm = '0;
  logic [2:0]      req_sew = '0;
  logic [1:0]      req_lmul = '0;
  logic            req_tail_agn = 1'b0, req_mask_agn = 1'b0;
  logic            req_src_zero = 1'b0, req_dst_zero = 1'b0;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_vl;
  logic [VLW-1:0]  vl_o;
  logic            vtype_ill_o, vtype_tail_agn_o, vtype_mask_agn_o;
  logic [2:0]      vtype_sew_o;
  logic [1:0]      vtype_lmul_o;

  int checks = 0, errors = 0;
  longint m_vl = 0;
  int m_ill = 1, m_sew = 0, m_lmul = 0, m_ta = 0, m_ma = 0;

  always #5 clk = ~clk;

  vcfg_unit #(.VLEN(VLEN), .XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_imm_form(req_imm_form), .req_avl_reg(req_avl_reg),
    .req_avl_imm(req_avl_imm), .req_sew(req_sew), .req_lmul(req_lmul),
    .req_tail_agn(req_tail_agn), .req_mask_agn(req_mask_agn),
    .req_src_zero(req_src_zero), .req_dst_zero(req_dst_zero),
    .rsp_valid(rsp_valid), .rsp_vl(rsp_vl), .vl_o(vl_o),
    .vtype_ill_o(vtype_ill_o), .vtype_sew_o(vtype_sew_o),
    .vtype_lmul_o(vtype_lmul_o), .vtype_tail_agn_o(vtype_tail_agn_o),
    .vtype_mask_agn_o(vtype_mask_agn_o));

  function automatic longint vlmax_m(int sew, int lmul);
    if (sew > 3) return 0;
    return longint'(VLEN / (8 * (1 << sew))) * longint'(1 << lmul);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " vl"}, longint'(vl_o), m_vl);
    check("R7 ill flag", longint'(vtype_ill_o), m_ill);
    check("R2 sew field", longint'(vtype_sew_o), m_sew);
    check("R2 lmul field", longint'(vtype_lmul_o), m_lmul);
    check("R8 tail policy", longint'(vtype_tail_agn_o), m_ta);
    check("R8 mask policy", longint'(vtype_mask_agn_o), m_ma);
  endtask

  task automatic issue(input int imm, input longint avl, input int immv,
                       input int sew, input int lmul, input int ta, input int ma,
                       input int sz, input int dz, input string tag);
    longint nm, om, av;
    int keep, maxm, ill;
    @(negedge clk);
    req_imm_form = imm[0]; req_avl_reg = avl[XLEN-1:0]; req_avl_imm = immv[4:0];
    req_sew = sew[2:0]; req_lmul = lmul[1:0]; req_tail_agn = ta[0];
    req_mask_agn = ma[0]; req_src_zero = sz[0]; req_dst_zero = dz[0];
    req_valid = 1'b1;
    check("R10 ready", longint'(req_ready), 1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    av   = imm ? longint'(immv) : (avl & 64'hFFFF_FFFF);
    keep = (!imm && sz && dz) ? 1 : 0;
    maxm = (!imm && sz && !dz) ? 1 : 0;
    nm   = vlmax_m(sew, lmul);
    om   = m_ill ? -1 : vlmax_m(m_sew, m_lmul);
    ill  = (sew > 3 || (keep && nm != om)) ? 1 : 0;
    if (ill) begin
      m_vl = 0; m_ill = 1; m_sew = 0; m_lmul = 0; m_ta = 0; m_ma = 0;
    end else begin
      if (maxm) m_vl = nm;
      else if (!keep) m_vl = (av >= nm) ? nm : av;
      m_ill = 0; m_sew = sew; m_lmul = lmul; m_ta = ta; m_ma = ma;
    end
    check("R9 rsp_valid", longint'(rsp_valid), 1);
    check("R9 rsp_vl", longint'(rsp_vl), m_vl);
    check_state(tag);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    req_avl_reg = 32'h5A5A_5A5A; req_sew = 3'd1; req_src_zero = 1'b1;
    @(posedge clk);
    #1;
    check("R9 rsp_valid drops", longint'(rsp_valid), 0);
    check_state("R10 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid at reset", longint'(rsp_valid), 0);
    check_state("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Register form: every code, AVL around the maximum (R2, R3, R7, R8).
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 4; l++) begin
        for (int k = 0; k < 6; k++) begin
          longint nm = vlmax_m(s, l);
          longint av;
          case (k)
            0: av = 0;
            1: av = 1;
            2: av = (nm - 1) & 64'hFFFF_FFFF;
            3: av = nm;
            4: av = nm + 1;
            default: av = 64'hFFFF_FFFF;
          endcase
          issue(0, av, 0, s, l, k & 1, (k >> 1) & 1, 0, k % 2, "R3 clamp");
        end
      end
      idle_check();
    end

    // Source x0, destination not x0: fill to maximum (R5, R2).
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 4; l++)
        issue(0, 3, 0, s, l, l & 1, s & 1, 1, 0, "R5 max fill");

    // Immediate form with every immediate; x0 flags set to show they are ignored (R4).
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 4; l++)
        for (int i = 0; i < 32; i++)
          issue(1, 64'hFFFF_FFFF, i, s, l, i & 1, (i >> 1) & 1, 1, 1, "R4 imm");

    // Type-only change from each legal type to every type (R6, R7).
    for (int bs = 0; bs < 4; bs++)
      for (int bl = 0; bl < 4; bl++)
        for (int s = 0; s < 8; s++)
          for (int l = 0; l < 4; l++) begin
            issue(0, 7, 0, bs, bl, 0, 1, 0, 0, "R3 base");
            issue(0, 0, 0, s, l, 1, 0, 1, 1, "R6 keep");
          end

    // Type-only change while the type is illegal stays illegal (R7).
    issue(0, 5, 0, 4, 0, 0, 0, 0, 0, "R7 illegal sew");
    issue(0, 0, 0, 0, 0, 1, 1, 1, 1, "R7 keep from illegal");
    idle_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule